// File: doc/BRIEF.md
# Unpacked-BCD Multiply/Divide Adjust Unit

This unit performs the two unpacked-BCD adjust steps that take an 8-bit immediate base. The split step turns a binary value held in the low byte of a 16-bit accumulator into two base-N digits. The quotient goes to the high byte and the remainder to the low byte. The combine step reverses this. It multiplies the high byte by the base, adds the low byte with a full 16-bit add, places the low byte of the sum in the low byte, and clears the high byte.

An execution pipeline drives the accumulator, the immediate and an operation select, and pulses start. The split step runs on an iterative restoring divider that produces one quotient bit per cycle. The combine step occupies a fixed number of cycles. A base of zero on the split step does not produce a result. It raises a one-cycle divide-error pulse that the surrounding core turns into an exception. Results and flags are registered and stay in place until the next completion.

Top module: `bcd_scale_adjust`

## Requirements
- R1: Split (op_i = 0): ax_o[15:8] becomes ax_i[7:0] / base_i and ax_o[7:0] becomes ax_i[7:0] % base_i. The incoming ax_i[15:8] has no effect on the result.
- R2: Split with base_i = 0: div_err_o and done_o are high together for one cycle after the edge that samples start. ax_o takes the sampled ax_i unchanged and flags_o keeps its previous value.
- R3: After a valid split, flags_o takes sign = ax_o[7], zero = (ax_o[7:0] == 0) and parity = 1 when ax_o[7:0] has an even number of ones. Carry, overflow and aux are 0. Flag positions are carry [0], parity [1], aux [2], zero [3], sign [4], overflow [5].
- R4: Combine (op_i = 1) forms S = ax_i[15:8] * base_i + ax_i[7:0] as a 16-bit add and writes S[7:0] to ax_o[7:0]. The flags are: carry = carry out of bit 15; overflow = signed overflow of the add; aux = carry out of bit 3; sign = S[15]; zero = (S == 0) over all 16 bits; parity = even parity of S[7:0]. The flag positions are those of R3.
- R5: After a combine, ax_o[15:8] is 0, and a zero base gives no error.
- R6: A combine completes with done_o high after the 60th rising edge, counting the edge that samples start as the first.
- R7: A valid split completes with done_o high after the 10th rising edge, counted the same way (data width plus two).
- R8: start_i while an operation is in progress is ignored. It does not change that operation's result or timing, and it produces no extra completion.
- R9: done_o is a one-cycle pulse per operation. ax_o and flags_o hold their values in every cycle in which done_o is low.
- R10: While reset is asserted, ax_o, flags_o, done_o and div_err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin an operation (sampled when idle) |
| op_i | input | 1 | 0 = split (divide), 1 = combine (multiply-add) |
| ax_i | input | 16 | Accumulator in: high byte and low byte |
| base_i | input | 8 | Immediate base |
| ax_o | output | 16 | Accumulator result |
| flags_o | output | 6 | Flags: carry, parity, aux, zero, sign, overflow (bits 0..5) |
| div_err_o | output | 1 | Divide-error pulse on zero base in split |
| done_o | output | 1 | Completion pulse |

## Verification
Several properties are checked on every cycle. Whenever the divider finishes, the quotient times the base plus the remainder must rebuild the dividend, and the remainder must stay below the base. A completed split must never show carry, aux or overflow, and a completed combine must never leave a nonzero high byte. The error pulse must carry the sampled input through unchanged, the latency of each operation kind is checked, and the outputs must stay stable between completions. Only the bench scenarios can show the exact digits and every flag for chosen corner values. Examples are a sum whose low byte is zero but whose high byte is not, a signed overflow, and a base of one, zero or 255. The scenarios also cover flags retained across an error and a start ignored in the middle of a long combine.

// File: rtl/adj_pkg.sv
package adj_pkg;
  typedef enum logic {
    OP_SPLIT   = 1'b0,
    OP_COMBINE = 1'b1
  } adj_op_e;

  localparam int FLAG_W    = 6;
  localparam int FL_CARRY  = 0;
  localparam int FL_PARITY = 1;
  localparam int FL_AUX    = 2;
  localparam int FL_ZERO   = 3;
  localparam int FL_SIGN   = 4;
  localparam int FL_OVF    = 5;
endpackage

// File: rtl/adj_divider.sv
module adj_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         fin_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  localparam int CNT_W = $clog2(W) + 1;

  logic [W-1:0]     shift_q;   // dividend bits out, quotient bits in
  logic [W-1:0]     rem_q;
  logic [W-1:0]     dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             fin_q;

  logic [W:0] rem_sh;
  logic [W:0] trial;
  logic       take;

  always_comb begin
    rem_sh = {rem_q, shift_q[W-1]};
    trial  = rem_sh - {1'b0, dvs_q};
    take   = (rem_sh >= {1'b0, dvs_q});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
      rem_q   <= '0;
      dvs_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      fin_q   <= 1'b0;
    end else if (load_i) begin
      shift_q <= dividend_i;
      rem_q   <= '0;
      dvs_q   <= divisor_i;
      cnt_q   <= '0;
      busy_q  <= 1'b1;
      fin_q   <= 1'b0;
    end else if (busy_q) begin
      shift_q <= {shift_q[W-2:0], take};
      rem_q   <= take ? trial[W-1:0] : rem_sh[W-1:0];
      cnt_q   <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(W - 1)) begin
        busy_q <= 1'b0;
        fin_q  <= 1'b1;
      end else begin
        fin_q  <= 1'b0;
      end
    end else begin
      fin_q <= 1'b0;
    end
  end

  assign fin_o  = fin_q;
  assign quot_o = shift_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/adj_combine.sv
module adj_combine
  import adj_pkg::*;
#(
  parameter int W      = 8,
  parameter int CYCLES = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [W-1:0]      hi_i,
  input  logic [W-1:0]      lo_i,
  input  logic [W-1:0]      scale_i,
  output logic              fin_o,
  output logic [2*W-1:0]    sum_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int W2    = 2 * W;
  localparam int CNT_W = $clog2(CYCLES) + 1;

  function automatic logic [W2:0] wide_add(input logic [W2-1:0] a, input logic [W2-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [FLAG_W-1:0] add_flags(input logic [W2-1:0] a, input logic [W2-1:0] b,
                                                  input logic [W2:0] full);
    logic [FLAG_W-1:0] f;
    logic [W2-1:0]     s;
    logic [W2-1:0]     carries;
    s            = full[W2-1:0];
    carries      = a ^ b ^ s;
    f            = '0;
    f[FL_CARRY]  = full[W2];
    f[FL_PARITY] = ~^s[W-1:0];
    f[FL_AUX]    = carries[4];
    f[FL_ZERO]   = (s == '0);
    f[FL_SIGN]   = s[W2-1];
    f[FL_OVF]    = (a[W2-1] == b[W2-1]) && (s[W2-1] != a[W2-1]);
    return f;
  endfunction

  logic [W2-1:0] prod;
  logic [W2-1:0] addend;
  logic [W2:0]   full;

  always_comb begin
    prod    = {{W{1'b0}}, hi_i} * {{W{1'b0}}, scale_i};
    addend  = {{W{1'b0}}, lo_i};
    full    = wide_add(prod, addend);
    sum_o   = full[W2-1:0];
    flags_o = add_flags(prod, addend, full);
  end

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             fin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= CNT_W'(1);
      busy_q <= 1'b1;
      fin_q  <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(CYCLES - 2)) begin
        busy_q <= 1'b0;
        fin_q  <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        fin_q  <= 1'b0;
      end
    end else begin
      fin_q <= 1'b0;
    end
  end

  assign fin_o = fin_q;
endmodule

// File: rtl/bcd_scale_adjust.sv
module bcd_scale_adjust
  import adj_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int COMBINE_CYCLES = 60
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                op_i,
  input  logic [2*DATA_W-1:0] ax_i,
  input  logic [DATA_W-1:0]   base_i,
  output logic [2*DATA_W-1:0] ax_o,
  output logic [FLAG_W-1:0]   flags_o,
  output logic                div_err_o,
  output logic                done_o
);
  localparam int W     = DATA_W;
  localparam int W2    = 2 * DATA_W;
  localparam int LAT_W = $clog2(COMBINE_CYCLES + DATA_W + 4) + 1;

  function automatic logic [FLAG_W-1:0] split_flags(input logic [W-1:0] r);
    logic [FLAG_W-1:0] f;
    f            = '0;
    f[FL_SIGN]   = r[W-1];
    f[FL_ZERO]   = (r == '0);
    f[FL_PARITY] = ~^r;
    return f;
  endfunction

  adj_op_e            op_q;
  logic               busy_q;
  logic [W2-1:0]      ax_in_q;
  logic [W-1:0]       base_q;
  logic [W2-1:0]      ax_q;
  logic [FLAG_W-1:0]  flags_q;
  logic               done_q;
  logic               err_q;

  // named internal events
  logic               accept;
  logic               zero_div;
  logic               div_load;
  logic               cmb_load;
  logic               div_fin;
  logic [W-1:0]       div_quot;
  logic [W-1:0]       div_rem;
  logic               cmb_fin;
  logic [W2-1:0]      cmb_sum;
  logic [FLAG_W-1:0]  cmb_flags;

  assign accept   = start_i && !busy_q;
  assign zero_div = accept && (op_i == OP_SPLIT) && (base_i == '0);
  assign div_load = accept && (op_i == OP_SPLIT) && (base_i != '0);
  assign cmb_load = accept && (op_i == OP_COMBINE);

  adj_divider #(.W(W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (div_load),
    .dividend_i (ax_i[W-1:0]),
    .divisor_i  (base_i),
    .fin_o      (div_fin),
    .quot_o     (div_quot),
    .rem_o      (div_rem)
  );

  adj_combine #(.W(W), .CYCLES(COMBINE_CYCLES)) u_cmb (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (cmb_load),
    .hi_i    (ax_in_q[W2-1:W]),
    .lo_i    (ax_in_q[W-1:0]),
    .scale_i (base_q),
    .fin_o   (cmb_fin),
    .sum_o   (cmb_sum),
    .flags_o (cmb_flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q    <= OP_SPLIT;
      busy_q  <= 1'b0;
      ax_in_q <= '0;
      base_q  <= '0;
      ax_q    <= '0;
      flags_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        op_q    <= adj_op_e'(op_i);
        ax_in_q <= ax_i;
        base_q  <= base_i;
        if (zero_div) begin
          ax_q   <= ax_i;
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end else begin
          busy_q <= 1'b1;
        end
      end else if (div_fin) begin
        ax_q    <= {div_quot, div_rem};
        flags_q <= split_flags(div_rem);
        done_q  <= 1'b1;
        busy_q  <= 1'b0;
      end else if (cmb_fin) begin
        ax_q    <= {{W{1'b0}}, cmb_sum[W-1:0]};
        flags_q <= cmb_flags;
        done_q  <= 1'b1;
        busy_q  <= 1'b0;
      end
    end
  end

  assign ax_o      = ax_q;
  assign flags_o   = flags_q;
  assign done_o    = done_q;
  assign div_err_o = err_q;

  // ---------------- assertions ----------------
  logic [W2-1:0]    div_recon;
  logic [LAT_W-1:0] lat_q;

  assign div_recon = {{W{1'b0}}, div_quot} * {{W{1'b0}}, base_q} + {{W{1'b0}}, div_rem};

  always_ff @(posedge clk) begin
    if (!rst_n)      lat_q <= '0;
    else if (accept) lat_q <= LAT_W'(1);
    else if (busy_q) lat_q <= lat_q + 1'b1;
  end

  assert_split_identity_R1: assert property (@(posedge clk) disable iff (!rst_n)
    div_fin |-> (div_recon == {{W{1'b0}}, ax_in_q[W-1:0]}) && (div_rem < base_q));

  assert_zero_div_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_err_o |-> done_o && (ax_o == $past(ax_i)) && $stable(flags_o));

  assert_split_flags_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !div_err_o && op_q == OP_SPLIT) |->
      !flags_o[FL_CARRY] && !flags_o[FL_AUX] && !flags_o[FL_OVF]);

  assert_high_byte_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && op_q == OP_COMBINE) |-> (ax_o[W2-1:W] == '0) && !div_err_o);

  assert_combine_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && op_q == OP_COMBINE) |-> (lat_q == LAT_W'(COMBINE_CYCLES)));

  assert_split_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !div_err_o && op_q == OP_SPLIT) |-> (lat_q == LAT_W'(DATA_W + 2)));

  assert_hold_between_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(ax_o) && $stable(flags_o));
endmodule

// File: tb/tb_bcd_scale_adjust.sv
module tb_bcd_scale_adjust;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        op_i = 1'b0;
  logic [15:0] ax_i = '0;
  logic [7:0]  base_i = '0;
  logic [15:0] ax_o;
  logic [5:0]  flags_o;
  logic        div_err_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bcd_scale_adjust dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .ax_i(ax_i), .base_i(base_i), .ax_o(ax_o), .flags_o(flags_o),
    .div_err_o(div_err_o), .done_o(done_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic even_par(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) if (v[i]) n++;
    return (n % 2) == 0;
  endfunction

  // flags: carry0 parity1 aux2 zero3 sign4 ovf5
  function automatic logic [5:0] mk_flags(input logic c, p, a, z, s, o);
    return {o, s, z, a, p, c};
  endfunction

  // issue one operation, return number of edges until done (sampled at negedge)
  task automatic issue(input logic op, input logic [15:0] ax, input logic [7:0] b, output int lat, output logic err);
    @(negedge clk);
    start_i = 1'b1; op_i = op; ax_i = ax; base_i = b;
    @(posedge clk); lat = 1;
    @(negedge clk);
    start_i = 1'b0; ax_i = 16'hC3C3; base_i = 8'h77;
    while (!done_o && lat < 300) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    err = div_err_o;
  endtask

  task automatic t_split(input logic [15:0] ax, input logic [7:0] b);
    int lat; logic err;
    int q, r;
    q = ax[7:0] / b; r = ax[7:0] % b;
    issue(1'b0, ax, b, lat, err);
    chk("R1", "split quotient", ax_o[15:8], q);
    chk("R1", "split remainder", ax_o[7:0], r);
    chk("R3", "split flags", flags_o,
        mk_flags(1'b0, even_par(8'(r)), 1'b0, r == 0, r >= 128, 1'b0));
    chk("R7", "split latency", lat, 10);
    chk("R2", "no error on valid split", err, 0);
  endtask

  task automatic t_combine(input logic [15:0] ax, input logic [7:0] b);
    int lat; logic err;
    int p, s, s16;
    logic c, o, a;
    p = ax[15:8] * b;
    s = p + ax[7:0];
    s16 = s % 65536;
    c = s > 65535;
    o = (p < 32768) && (s16 >= 32768);
    a = ((p % 16) + (ax[7:0] % 16)) > 15;
    issue(1'b1, ax, b, lat, err);
    chk("R4", "combine low byte", ax_o[7:0], s16 % 256);
    chk("R5", "combine high byte zero", ax_o[15:8], 0);
    chk("R4", "combine flags", flags_o,
        mk_flags(c, even_par(8'(s16 % 256)), a, s16 == 0, s16 >= 32768, o));
    chk("R6", "combine latency", lat, 60);
    chk("R5", "no error on combine", err, 0);
  endtask

  task automatic t_zero_div(input logic [15:0] ax);
    int lat; logic err;
    logic [5:0] prev;
    prev = flags_o;
    issue(1'b0, ax, 8'h00, lat, err);
    chk("R2", "error pulse", err, 1);
    chk("R2", "error latency", lat, 1);
    chk("R2", "ax unchanged", ax_o, ax);
    chk("R2", "flags kept", flags_o, prev);
    @(negedge clk);
    chk("R9", "error pulse one cycle", {div_err_o, done_o}, 0);
  endtask

  task automatic t_ignore_start;
    int lat; int extra;
    @(negedge clk);
    start_i = 1'b1; op_i = 1'b1; ax_i = 16'h0709; base_i = 8'd10;
    @(posedge clk); lat = 1;
    @(negedge clk); start_i = 1'b0;
    repeat (5) begin @(posedge clk); lat++; @(negedge clk); end
    start_i = 1'b1; op_i = 1'b0; ax_i = 16'h00FF; base_i = 8'h00;
    @(posedge clk); lat++;
    @(negedge clk); start_i = 1'b0;
    chk("R8", "no error from ignored start", div_err_o, 0);
    while (!done_o && lat < 300) begin @(posedge clk); lat++; @(negedge clk); end
    chk("R8", "latency kept", lat, 60);
    chk("R8", "result of first op", ax_o, 16'h004F);
    extra = 0;
    repeat (20) begin @(negedge clk); if (done_o) extra++; end
    chk("R8", "no extra completion", extra, 0);
  endtask

  task automatic t_hold;
    logic [15:0] a; logic [5:0] f; int moved;
    a = ax_o; f = flags_o; moved = 0;
    @(negedge clk); ax_i = 16'hFFFF; base_i = 8'h01; op_i = 1'b1;
    repeat (8) begin
      @(negedge clk);
      if (ax_o !== a || flags_o !== f || done_o) moved++;
    end
    chk("R9", "outputs held while idle", moved, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "reset ax", ax_o, 0);
    chk("R10", "reset flags", flags_o, 0);
    chk("R10", "reset done/err", {done_o, div_err_o}, 0);
    rst_n = 1'b1;
    t_split(16'hAB4F, 8'd10);     // R1: 79/10, AH ignored
    t_split(16'h00FF, 8'h10);
    t_split(16'h5580, 8'h01);     // zero remainder
    t_split(16'h00FE, 8'hFF);     // quotient 0, sign set
    t_hold();
    t_zero_div(16'h1234);
    t_combine(16'h0709, 8'd10);   // 79
    t_zero_div(16'hBEEF);         // flags kept from combine
    t_combine(16'hFFFF, 8'hFF);   // low byte zero, 16-bit sum nonzero
    t_combine(16'h8080, 8'hFF);   // signed overflow
    t_combine(16'h0533, 8'h00);   // zero base on combine
    t_ignore_start();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule